// File: doc/BRIEF.md
# Ping-Pong Scan Line Buffer with Foreground/Background Merge

This block holds two line memories for a raster display and swaps their roles at the start of every scan line. One memory, the display side, is read out pixel by pixel as the horizontal counter sweeps the line. The other memory, the fill side, takes writes from the object-drawing logic while that readout runs, so it is ready for the following line.

During readout, each stored foreground pixel is merged with a pixel from a separate background stream. A foreground pixel that is present always wins over the background. Each display-side location is cleared as it is read. The memory that has just been shown is therefore empty when it next becomes the fill side, and the drawing logic only has to write the pixels that objects cover.

A pixel is 6 bits wide. Bits [5:4] are the intensity and bits [3:0] are the colour. A pixel counts as present when its intensity is non-zero.

Top module: `scan_line_mixer`

## Requirements
- R1: While rst_ni is low, pix_o is 0. After reset, bank 0 is the display side, bank 1 is the fill side, and every location of both banks reads as empty (zero).
- R2: A write (wr_en_i high) stores wr_data_i at wr_addr_i in the fill bank only. It never changes what the display bank returns during the same line.
- R3: A cycle with line_start_i high swaps the display and fill banks from the next cycle on. A read or write in that same cycle still uses the old roles.
- R4: A read (rd_en_i high) takes rd_addr_i and bg_pix_i in one cycle and presents the merged pixel on pix_o after the next rising clock edge, one cycle of latency.
- R5: When the stored foreground pixel has non-zero intensity (bits [5:4]), pix_o equals that foreground pixel and the background is suppressed.
- R6: When the foreground intensity is zero and the background intensity (bits [5:4] of bg_pix_i) is non-zero, pix_o equals bg_pix_i.
- R7: When both intensities are zero, pix_o is all zeros, whatever the colour bits hold.
- R8: A display-bank location is cleared to zero by the read that consumes it. A second read of that location in the same line, or a read after the bank has been through a fill side with no write there, shows background only.
- R9: With rd_en_i low, pix_o is 0 one cycle later and the display bank is left unchanged.
- R10: Each bank covers the full address range 0 to 255, both ends included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Scan-line start strobe; swaps bank roles |
| wr_en_i | input | 1 | Fill-side write enable |
| wr_addr_i | input | 8 | Fill-side pixel address |
| wr_data_i | input | 6 | Fill-side pixel value {intensity[1:0], colour[3:0]} |
| rd_en_i | input | 1 | Display-side readout enable (active part of line) |
| rd_addr_i | input | 8 | Horizontal counter, display-side address |
| bg_pix_i | input | 6 | Background pixel aligned with rd_addr_i |
| pix_o | output | 6 | Merged pixel, registered |

## Verification
The bench aims at the cycle where line_start_i and a write coincide. A design that switched roles too early would put that write into the bank being shown and lose it from the next line. It re-reads addresses within one line and reads a bank that was never rewritten after display. A design that failed to clear on read would show stale sprites, and one that cleared the wrong bank would erase freshly drawn pixels. It drives pixels that have zero intensity but non-zero colour, in both foreground and background. A merge keyed on the whole pixel rather than on intensity would let such pixels through or hide the background. It also holds rd_en_i low over a loaded address and then reads that address, which exposes a design that clears or outputs during blanking.

// File: rtl/scanmix_pkg.sv
package scanmix_pkg;
  localparam int unsigned INT_W = 2;
  localparam int unsigned COL_W = 4;
  localparam int unsigned PIX_W = INT_W + COL_W;

  typedef struct packed {
    logic [INT_W-1:0] inten;
    logic [COL_W-1:0] color;
  } pix_t;

  function automatic logic pix_present(pix_t p);
    return |p.inten;
  endfunction
endpackage

// File: rtl/scanmix_line_ram.sv
module scanmix_line_ram
  import scanmix_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  pix_t              wdata_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output pix_t              rdata_o
);
  pix_t mem_q [DEPTH];

  assign rdata_o = mem_q[raddr_i];

  // a bank is never fill and display side at once, so we_i and clr_i are exclusive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (we_i)  mem_q[waddr_i] <= wdata_i;
      if (clr_i) mem_q[raddr_i] <= '0;
    end
  end
endmodule

// File: rtl/scanmix_bank_ctl.sv
module scanmix_bank_ctl #(
  parameter int unsigned NBANK = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic             disp_sel_o,
  output logic [NBANK-1:0] bank_we_o,
  output logic [NBANK-1:0] bank_clr_o
);
  logic disp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           disp_q <= 1'b0;
    else if (line_start_i) disp_q <= ~disp_q;
  end

  assign disp_sel_o = disp_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_en
    assign bank_clr_o[b] = rd_en_i && (disp_q == 1'(b));
    assign bank_we_o[b]  = wr_en_i && (disp_q != 1'(b));
  end
endmodule

// File: rtl/scanmix_merge.sv
module scanmix_merge
  import scanmix_pkg::*;
(
  input  pix_t fg_i,
  input  pix_t bg_i,
  output pix_t mix_o
);
  always_comb begin
    if (pix_present(fg_i))      mix_o = fg_i;
    else if (pix_present(bg_i)) mix_o = bg_i;
    else                        mix_o = '0;
  end
endmodule

// File: rtl/scan_line_mixer.sv
module scan_line_mixer
  import scanmix_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned NBANK  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [PIX_W-1:0]  bg_pix_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic             disp_sel;
  logic [NBANK-1:0] bank_we;
  logic [NBANK-1:0] bank_clr;
  pix_t             bank_rd [NBANK];
  pix_t             fg_pix;
  pix_t             mix_pix;
  pix_t             pix_q;

  scanmix_bank_ctl #(.NBANK(NBANK)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .disp_sel_o   (disp_sel),
    .bank_we_o    (bank_we),
    .bank_clr_o   (bank_clr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    scanmix_line_ram #(.DEPTH(DEPTH)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we[b]),
      .waddr_i (wr_addr_i),
      .wdata_i (pix_t'(wr_data_i)),
      .clr_i   (bank_clr[b]),
      .raddr_i (rd_addr_i),
      .rdata_o (bank_rd[b])
    );
  end

  assign fg_pix = bank_rd[disp_sel];

  scanmix_merge u_merge (
    .fg_i  (fg_pix),
    .bg_i  (pix_t'(bg_pix_i)),
    .mix_o (mix_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pix_q <= '0;
    else if (rd_en_i) pix_q <= mix_pix;
    else              pix_q <= '0;
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/scan_line_mixer_chk.sv
module scan_line_mixer_chk
  import scanmix_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_start_i,
  input logic             rd_en_i,
  input logic [PIX_W-1:0] bg_pix_i,
  input logic [PIX_W-1:0] fg_pix,
  input logic             disp_sel,
  input logic [PIX_W-1:0] pix_o
);
  localparam int unsigned IH = PIX_W - 1;

  // R1
  always_comb if (!rst_ni) reset_out_chk: assert (pix_o == '0);

  // R3
  bank_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> disp_sel != $past(disp_sel));

  // R3
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(disp_sel));

  // R5
  fg_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (fg_pix[IH -: INT_W] != '0)) |=> pix_o == $past(fg_pix));

  // R6
  bg_shows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (fg_pix[IH -: INT_W] == '0) && (bg_pix_i[IH -: INT_W] != '0))
      |=> pix_o == $past(bg_pix_i));

  // R7
  dark_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o[IH -: INT_W] == '0) |-> pix_o == '0);

  // R9
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> pix_o == '0);
endmodule

bind scan_line_mixer scan_line_mixer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .rd_en_i      (rd_en_i),
  .bg_pix_i     (bg_pix_i),
  .fg_pix       (fg_pix),
  .disp_sel     (disp_sel),
  .pix_o        (pix_o)
);

// File: tb/scan_line_mixer_test.sv
module scan_line_mixer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_start_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [5:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_addr_i = '0;
  logic [5:0] bg_pix_i = '0;
  logic [5:0] pix_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit drv_v = 1'b0;
  bit mon_v = 1'b0;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];
  logic [5:0] mdl [2][256];
  int sel_m = 0;

  always #10 clk_i = ~clk_i;

  scan_line_mixer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .bg_pix_i(bg_pix_i),
    .pix_o(pix_o)
  );

  function automatic logic [5:0] fgpat(int a, int k);
    return 6'(a * 7 + k * 13);
  endfunction

  function automatic logic [5:0] bgpat(int a);
    return 6'(a * 5 + 3);
  endfunction

  task automatic check(logic [5:0] act, logic [5:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pix_o=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle and push its expected result
  task automatic cyc(bit ls, bit we, int wa, logic [5:0] wd,
                     bit re, int ra, logic [5:0] bg, string tag);
    item_t it;
    logic [5:0] fg;
    @(negedge clk_i);
    line_start_i = ls; wr_en_i = we; wr_addr_i = 8'(wa); wr_data_i = wd;
    rd_en_i = re; rd_addr_i = 8'(ra); bg_pix_i = bg; drv_v = 1'b1;
    if (re) begin
      fg = mdl[sel_m][ra];
      mdl[sel_m][ra] = '0;
      if (fg[5:4] != 2'b00) begin
        it.exp = fg;  it.tag = {tag, "/R5"};
      end else if (bg[5:4] != 2'b00) begin
        it.exp = bg;  it.tag = {tag, "/R6"};
      end else begin
        it.exp = '0;  it.tag = {tag, "/R7"};
      end
    end else begin
      it.exp = '0; it.tag = {tag, "/R9"};
    end
    if (we) mdl[1 - sel_m][wa] = wd;
    if (ls) sel_m = 1 - sel_m;
    sb.push_back(it);
  endtask

  always @(posedge clk_i) mon_v <= drv_v;

  always @(negedge clk_i) begin
    if (mon_v) begin
      item_t it;
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4: pix_o=%h expected=none (empty scoreboard)", pix_o);
      end else begin
        it = sb.pop_front();
        check(pix_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 256; a++) mdl[b][a] = '0;
    repeat (3) @(negedge clk_i);
    check(pix_o, 6'h00, "R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R10: display bank 0 empty after reset; fill bank 1 meanwhile (R2)
    for (int a = 0; a < 256; a++)
      cyc(0, 1, a, fgpat(a, 1), 1, a, bgpat(a), "R1_R2_R10");
    // R3: write in the swap cycle lands in the old fill bank
    cyc(1, 1, 0, 6'h1a, 0, 0, 6'h00, "R3");
    // R2: reading bank 1 while writing the same addresses into bank 0
    for (int a = 0; a < 256; a++)
      cyc(0, 1, a, fgpat(a, 2), 1, a, bgpat(a + 9), "R2_R3_R10");
    // R8: second read in the same line shows background only
    for (int a = 0; a < 16; a++)
      cyc(0, 0, 0, 6'h00, 1, a, bgpat(a + 1), "R8");
    cyc(0, 0, 0, 6'h00, 1, 255, 6'h0f, "R8_R10");
    // R9: blanking over a loaded address, then read it
    cyc(1, 0, 0, 6'h00, 0, 10, 6'h3f, "R9");
    cyc(0, 0, 0, 6'h00, 0, 10, 6'h3f, "R9");
    cyc(0, 0, 0, 6'h00, 1, 10, 6'h00, "R9");
    // R7: zero-intensity colours on both sides
    cyc(0, 0, 0, 6'h00, 1, 10, 6'h0c, "R7");
    // R8: bank 1 was fully consumed; after swap it reads empty
    cyc(1, 0, 0, 6'h00, 0, 0, 6'h00, "R3");
    for (int a = 0; a < 256; a++)
      cyc(0, 0, 0, 6'h00, 1, a, bgpat(a + 4), "R8");
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 64) == 0, $urandom % 2, $urandom % 256, 6'($urandom),
          ($urandom % 4) != 0, $urandom % 256, 6'($urandom), "R4");
    cyc(0, 0, 0, 6'h00, 0, 0, 6'h00, "R9");
    @(negedge clk_i);
    drv_v = 1'b0;
    repeat (3) @(negedge clk_i);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R4: pending=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule